// File: doc/BRIEF.md
# Cartridge Disk Controller Register Interface

This block is the bus-facing register file of a controller that serves up to four cartridge disk drives. It has five 16-bit word registers: control/status, bus address, disk address, a multipurpose register, and a bus-address extension. Each register can be written as a whole word or one byte at a time, and is read back over a simple read strobe. The block builds the error summary and handles the done and interrupt-enable bits. When software writes the control word with done clear, the block sends a one-cycle command strobe, with the function code and the drive number, to the seek and transfer logic.

The transfer logic reports back through three inputs. A completion pulse carries an error vector. A busy flag per drive feeds the ready bit. A per-entry load port fills the multipurpose queue with status or header words. The multipurpose register is a short queue that moves forward by one entry on each read. A build parameter selects an older bus variant. In that variant the extension register does not exist, and any access to its offset raises a bus-error output.

Top module: `cart_disk_regs`

## Requirements
- R1: The register is chosen by `bus_addr[3:1]`: 0 control/status, 1 bus address, 2 disk address, 3 multipurpose, 4 extension. Selections 5 to 7 read as 0 and ignore writes.
- R2: With `bus_byte`=1, the byte travels on `bus_wdata[7:0]`. If `bus_addr[0]`=1 it replaces bits 15:8, and if `bus_addr[0]`=0 it replaces bits 7:0. The other byte keeps its value. This applies to the control, address and multipurpose registers.
- R3: Control/status layout: bit 0 ready, bits 3:1 function, bit 6 interrupt enable, bit 7 done, bits 9:8 drive. Ready reads 1 when the selected drive's `drv_busy` bit is 0, and ready cannot be written.
- R4: Control/status error flags sit in bits 14:10 and are loaded from `xfer_err[4:0]` (bit 10 incomplete, 11 CRC, 12 header, 13 missing memory, 14 drive error). Bus writes cannot set them. Bit 15 reads 1 whenever any of them is 1.
- R5: Control/status bits 5:4 always read the same as extension bits 1:0. A control/status write updates extension bits 1:0, and an extension write shows in control/status bits 5:4.
- R6: A control/status write with bit 7 = 1 does not pulse `cmd_start`. After it, `irq` equals the written interrupt-enable bit.
- R7: A control/status write with bit 7 = 0 clears `irq` and all error flags. On the following cycle it pulses `cmd_start` for one cycle, with `cmd_func` and `cmd_drive` taken from the written value.
- R8: A multipurpose write loads every queue entry with the merged value. A read returns the head entry and moves each later entry forward, and the last entry keeps its value. A pulse on `mp_set[i]` loads entry i from `mp_set_data` (entry i in bits 16i+15:16i).
- R9: Bit 0 of the bus address always reads 0.
- R10: The extension register is 6 bits wide and reads zero-extended. An odd-byte write to it is ignored. With `LEGACY_BUS`=1, any access to selection 4 drives `bus_err`=1 and reads 0, and its writes have no effect.
- R11: A pulse on `xfer_done` sets done, ORs `xfer_err` into the error flags, and sets `irq` equal to interrupt enable. If a control/status write arrives in the same cycle, the write wins and the completion is dropped.
- R12: Reset leaves done=1 and every other register bit, queue entry, `irq` and `cmd_start` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | 4 | Bits 3:1 select the register, bit 0 selects the byte lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| bus_err | output | 1 | Access to an absent register (legacy variant only) |
| drv_busy | input | NUM_DRIVES | Per-drive busy flags |
| xfer_done | input | 1 | Completion pulse from seek/transfer logic |
| xfer_err | input | 5 | Error flags that come with `xfer_done` |
| mp_set | input | MP_DEPTH | Per-entry load strobes for the multipurpose queue |
| mp_set_data | input | 16*MP_DEPTH | Load data, entry i in bits 16i+15:16i |
| cmd_start | output | 1 | One-cycle command launch strobe |
| cmd_func | output | 3 | Stored function code |
| cmd_drive | output | 2 | Stored drive number |
| irq | output | 1 | Interrupt request level |

## Verification
The bench targets the corner cases where a register file like this usually goes wrong:
- **Byte writes on each lane.** A wrong merge would zero or overwrite the neighbouring byte.
- **Mirroring in both directions.** A broken mirror lets the extension bits and the control bits 5:4 drift apart.
- **Writing error bits from the bus.** If the error flags were writable, stray data would raise a false error summary.
- **Queue underrun and overload.** The bench reads the queue past its depth, which shows whether the tail holds its value or shifts in zeros. It also loads the queue with distinct entries, which shows whether the shift order is wrong.
- **Done and interrupt cases.** Writes with done set never start a command. A completion that meets a control write in the same cycle must lose, or the new command would appear already finished.
- **Legacy instance.** A second copy built for the legacy bus checks that the missing extension raises a bus error and leaves the mirrored bits alone.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
   localparam int WORD_W  = 16;
   localparam int NUM_ERR = 5;
   localparam int FUNC_W  = 3;
   localparam int DRV_W   = 2;

   // register selections on bus_addr[3:1]
   localparam logic [2:0] SEL_CSR   = 3'd0;
   localparam logic [2:0] SEL_BADDR = 3'd1;
   localparam logic [2:0] SEL_DADDR = 3'd2;
   localparam logic [2:0] SEL_MPQ   = 3'd3;
   localparam logic [2:0] SEL_EXT   = 3'd4;

   // control/status bit positions
   localparam int CS_READY = 0;
   localparam int CS_FUNC  = 1;
   localparam int CS_MEX   = 4;
   localparam int CS_IE    = 6;
   localparam int CS_DONE  = 7;
   localparam int CS_DRV   = 8;
   localparam int CS_ERR   = 10;
   localparam int CS_SUM   = 15;
endpackage

// File: rtl/cdr_lane_merge.sv
module cdr_lane_merge #(
   parameter int W = 16
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] wdata_i,
   input  logic         byte_i,
   input  logic         odd_i,
   output logic [W-1:0] merged_o
);
   localparam int HALF = W / 2;

   generate
      if ((W % 2) != 0 || W < 2) begin : g_bad_width
         $error("cdr_lane_merge: W must be even");
      end
   endgenerate

   always_comb begin
      merged_o = wdata_i;
      if (byte_i) begin
         if (odd_i) merged_o = {wdata_i[HALF-1:0], cur_i[HALF-1:0]};
         else       merged_o = {cur_i[W-1:HALF], wdata_i[HALF-1:0]};
      end
   end
endmodule

// File: rtl/cdr_mp_queue.sv
module cdr_mp_queue #(
   parameter int W     = 16,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [W-1:0]     load_data_i,
   input  logic [DEPTH-1:0] set_i,
   input  logic [DEPTH*W-1:0] set_data_i,
   input  logic             pop_i,
   output logic [W-1:0]     head_o
);
   logic [W-1:0] q [DEPTH];

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("cdr_mp_queue: DEPTH must be at least 1");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         if (i == DEPTH - 1) begin : g_tail
            // last entry holds its value across a pop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        q[i] <= '0;
               else if (load_i)   q[i] <= load_data_i;
               else if (set_i[i]) q[i] <= set_data_i[i*W +: W];
            end
         end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        q[i] <= '0;
               else if (load_i)   q[i] <= load_data_i;
               else if (set_i[i]) q[i] <= set_data_i[i*W +: W];
               else if (pop_i)    q[i] <= q[i+1];
            end
         end
      end
   endgenerate

   assign head_o = q[0];

   assert_load_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (q[DEPTH-1] == $past(load_data_i) && q[0] == $past(load_data_i)));

   generate
      if (DEPTH > 1) begin : g_chk_shift
         assert_pop_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_i && !load_i && set_i == '0) |=> (q[0] == $past(q[1])));
      end
   endgenerate
endmodule

// File: rtl/cdr_csr_ctl.sv
module cdr_csr_ctl
   import cdr_pkg::*;
#(
   parameter int NUM_DRIVES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [NUM_DRIVES-1:0] busy_i,
   input  logic [1:0]        mex_i,
   input  logic              done_i,
   input  logic [NUM_ERR-1:0] err_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              start_o,
   output logic [FUNC_W-1:0] func_o,
   output logic [DRV_W-1:0]  drive_o,
   output logic              irq_o
);
   localparam int DRV_SLOTS = 1 << DRV_W;

   logic [FUNC_W-1:0]  func_q;
   logic [DRV_W-1:0]   drive_q;
   logic [NUM_ERR-1:0] err_q;
   logic               ie_q, done_q, irq_q, start_q;
   logic [DRV_SLOTS-1:0] busy_pad;
   logic               ready;

   generate
      for (genvar i = 0; i < DRV_SLOTS; i++) begin : g_busy
         if (i < NUM_DRIVES) begin : g_have
            assign busy_pad[i] = busy_i[i];
         end else begin : g_absent
            assign busy_pad[i] = 1'b1;
         end
      end
   endgenerate

   assign ready = ~busy_pad[drive_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         func_q  <= '0;
         drive_q <= '0;
         err_q   <= '0;
         ie_q    <= 1'b0;
         done_q  <= 1'b1;
         irq_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (wr_i) begin
            func_q  <= wdata_i[CS_FUNC +: FUNC_W];
            drive_q <= wdata_i[CS_DRV +: DRV_W];
            ie_q    <= wdata_i[CS_IE];
            done_q  <= wdata_i[CS_DONE];
            if (wdata_i[CS_DONE]) begin
               irq_q <= wdata_i[CS_IE];
            end else begin
               irq_q   <= 1'b0;
               err_q   <= '0;
               start_q <= 1'b1;
            end
         end else if (done_i) begin
            done_q <= 1'b1;
            err_q  <= err_q | err_i;
            irq_q  <= ie_q;
         end
      end
   end

   assign rdata_o = {|err_q, err_q, drive_q, done_q, ie_q, mex_i, func_q, ready};
   assign start_o = start_q;
   assign func_o  = func_q;
   assign drive_o = drive_q;
   assign irq_o   = irq_q;

   logic unused_wbits;
   assign unused_wbits = ^{wdata_i[WORD_W-1:CS_ERR], wdata_i[CS_MEX +: 2], wdata_i[CS_READY]};

   assert_irq_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (done_q && ie_q));
   assert_start_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (!done_q && err_q == '0 && !irq_q));
   assert_done_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[CS_DONE]) |=> !start_q);
   assert_completion_sets_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !wr_i) |=> done_q);
endmodule

// File: rtl/cart_disk_regs.sv
module cart_disk_regs
   import cdr_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int EXT_W      = 6,
   parameter int MP_DEPTH   = 3,
   parameter bit LEGACY_BUS = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic                       bus_byte,
   input  logic [3:0]                 bus_addr,
   input  logic [15:0]                bus_wdata,
   output logic [15:0]                bus_rdata,
   output logic                       bus_err,
   input  logic [NUM_DRIVES-1:0]      drv_busy,
   input  logic                       xfer_done,
   input  logic [4:0]                 xfer_err,
   input  logic [MP_DEPTH-1:0]        mp_set,
   input  logic [16*MP_DEPTH-1:0]     mp_set_data,
   output logic                       cmd_start,
   output logic [2:0]                 cmd_func,
   output logic [1:0]                 cmd_drive,
   output logic                       irq
);
   localparam bit EXT_PRESENT = !LEGACY_BUS;

   generate
      if (NUM_DRIVES < 1 || NUM_DRIVES > (1 << DRV_W)) begin : g_bad_drives
         $error("cart_disk_regs: NUM_DRIVES out of range");
      end
      if (EXT_W < 2 || EXT_W > WORD_W) begin : g_bad_ext
         $error("cart_disk_regs: EXT_W out of range");
      end
      if (MP_DEPTH < 1 || MP_DEPTH > 8) begin : g_bad_depth
         $error("cart_disk_regs: MP_DEPTH out of range");
      end
   endgenerate

   logic [2:0]        sel;
   logic              odd;
   logic [WORD_W-1:0] cur, merged, csr_rd, mp_head, ext_rd;
   logic [WORD_W-1:0] baddr_q, daddr_q;
   logic [EXT_W-1:0]  ext_q;
   logic              csr_wr, ext_wr_ok, ext_hit;

   assign sel     = bus_addr[3:1];
   assign odd     = bus_addr[0];
   assign csr_wr  = bus_wr && (sel == SEL_CSR);
   assign ext_hit = (bus_wr || bus_rd) && (sel == SEL_EXT);
   assign ext_rd  = EXT_PRESENT ? WORD_W'(ext_q) : '0;

   always_comb begin
      case (sel)
         SEL_CSR:   cur = csr_rd;
         SEL_BADDR: cur = baddr_q;
         SEL_DADDR: cur = daddr_q;
         SEL_MPQ:   cur = mp_head;
         SEL_EXT:   cur = ext_rd;
         default:   cur = '0;
      endcase
   end

   cdr_lane_merge #(.W(WORD_W)) u_merge (
      .cur_i    (cur),
      .wdata_i  (bus_wdata),
      .byte_i   (bus_byte),
      .odd_i    (odd),
      .merged_o (merged)
   );

   cdr_csr_ctl #(.NUM_DRIVES(NUM_DRIVES)) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (csr_wr),
      .wdata_i (merged),
      .busy_i  (drv_busy),
      .mex_i   (ext_q[1:0]),
      .done_i  (xfer_done),
      .err_i   (xfer_err),
      .rdata_o (csr_rd),
      .start_o (cmd_start),
      .func_o  (cmd_func),
      .drive_o (cmd_drive),
      .irq_o   (irq)
   );

   cdr_mp_queue #(.W(WORD_W), .DEPTH(MP_DEPTH)) u_mpq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (bus_wr && (sel == SEL_MPQ)),
      .load_data_i (merged),
      .set_i       (mp_set),
      .set_data_i  (mp_set_data),
      .pop_i       (bus_rd && (sel == SEL_MPQ)),
      .head_o      (mp_head)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         baddr_q <= '0;
         daddr_q <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_BADDR) baddr_q <= {merged[WORD_W-1:1], 1'b0};
         if (sel == SEL_DADDR) daddr_q <= merged;
      end
   end

   // extension register: low two bits shared with control/status bits 5:4
   generate
      if (EXT_PRESENT) begin : g_ext_full
         assign ext_wr_ok = bus_wr && (sel == SEL_EXT) && !odd;
         assign bus_err   = 1'b0;
      end else begin : g_ext_absent
         assign ext_wr_ok = 1'b0;
         assign bus_err   = ext_hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ext_q      <= '0;
      else if (csr_wr)    ext_q[1:0] <= merged[CS_MEX +: 2];
      else if (ext_wr_ok) ext_q      <= merged[EXT_W-1:0];
   end

   assign bus_rdata = (bus_rd && !bus_err) ? cur : '0;

   assert_unused_sel_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel > SEL_EXT) |-> (bus_rdata == '0));
   assert_ext_err_variant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_hit |-> (bus_err == LEGACY_BUS));
   assert_ext_odd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_EXT && odd) |=> $stable(ext_q));
   assert_baddr_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_BADDR) |-> (bus_rdata[0] == 1'b0));
   assert_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_CSR) |-> (bus_rdata[CS_MEX +: 2] == ext_q[1:0]));
endmodule

// File: tb/cart_disk_regs_bench.sv
module cart_disk_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [3:0]  drv_busy = '0;
   logic        xfer_done = 1'b0;
   logic [4:0]  xfer_err = '0;
   logic [2:0]  mp_set = '0;
   logic [47:0] mp_set_data = '0;

   logic [15:0] rdata, rdata_l;
   logic        berr, berr_l;
   logic        cmd_start, cmd_start_l, irq, irq_l;
   logic [2:0]  cmd_func, cmd_func_l;
   logic [1:0]  cmd_drive, cmd_drive_l;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cart_disk_regs u_cart_disk_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_byte(bus_byte),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .bus_err(berr),
      .drv_busy(drv_busy), .xfer_done(xfer_done), .xfer_err(xfer_err),
      .mp_set(mp_set), .mp_set_data(mp_set_data), .cmd_start(cmd_start),
      .cmd_func(cmd_func), .cmd_drive(cmd_drive), .irq(irq));

   cart_disk_regs #(.LEGACY_BUS(1'b1)) u_cart_disk_regs_legacy (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_byte(bus_byte),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .bus_err(berr_l),
      .drv_busy(drv_busy), .xfer_done(xfer_done), .xfer_err(xfer_err),
      .mp_set(mp_set), .mp_set_data(mp_set_data), .cmd_start(cmd_start_l),
      .cmd_func(cmd_func_l), .cmd_drive(cmd_drive_l), .irq(irq_l));

   typedef struct packed {
      logic        wr;
      logic        byt;
      logic [3:0]  a;
      logic [15:0] d;
      logic [15:0] e;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 19;
   localparam vec_t TBL [NVEC] = '{
      '{1'b1, 1'b0, 4'h2, 16'hABCD, 16'h0000, 4'd9},   // R9 word write bus address
      '{1'b0, 1'b0, 4'h2, 16'h0000, 16'hABCC, 4'd9},   // R9 bit 0 reads 0
      '{1'b1, 1'b1, 4'h3, 16'h0012, 16'h0000, 4'd2},   // R2 high byte
      '{1'b0, 1'b0, 4'h2, 16'h0000, 16'h12CC, 4'd2},
      '{1'b1, 1'b1, 4'h2, 16'h0077, 16'h0000, 4'd2},   // R2 low byte
      '{1'b0, 1'b0, 4'h2, 16'h0000, 16'h1276, 4'd2},
      '{1'b1, 1'b0, 4'h4, 16'hFFFF, 16'h0000, 4'd1},   // R1 disk address
      '{1'b0, 1'b0, 4'h4, 16'h0000, 16'hFFFF, 4'd1},
      '{1'b1, 1'b1, 4'h4, 16'h005A, 16'h0000, 4'd2},
      '{1'b0, 1'b0, 4'h4, 16'h0000, 16'hFF5A, 4'd2},
      '{1'b1, 1'b0, 4'h8, 16'hFFFF, 16'h0000, 4'd10},  // R10 six bits kept
      '{1'b0, 1'b0, 4'h8, 16'h0000, 16'h003F, 4'd10},
      '{1'b1, 1'b1, 4'h9, 16'h0000, 16'h0000, 4'd10},  // R10 odd byte ignored
      '{1'b0, 1'b0, 4'h8, 16'h0000, 16'h003F, 4'd10},
      '{1'b0, 1'b0, 4'hA, 16'h0000, 16'h0000, 4'd1},   // R1 unused selection
      '{1'b1, 1'b0, 4'hC, 16'hFFFF, 16'h0000, 4'd1},
      '{1'b0, 1'b0, 4'h4, 16'h0000, 16'hFF5A, 4'd1},
      '{1'b1, 1'b0, 4'h8, 16'h0002, 16'h0000, 4'd10},
      '{1'b0, 1'b0, 4'h8, 16'h0000, 16'h0002, 4'd10}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic byt, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_byte = 1'b0;
   endtask

   task automatic do_read(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic complete(input logic [4:0] e);
      @(negedge clk);
      xfer_done = 1'b1; xfer_err = e;
      @(negedge clk);
      xfer_done = 1'b0; xfer_err = '0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [15:0] v;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      do_read(4'h0, v); check("R12 csr", v, 16'h0081);
      check("R12 irq", {15'b0, irq}, 16'h0000);
      check("R12 cmd_start", {15'b0, cmd_start}, 16'h0000);
      do_read(4'h6, v); check("R12 mp", v, 16'h0000);

      for (int i = 0; i < NVEC; i++) begin
         if (TBL[i].wr) do_write(TBL[i].byt, TBL[i].a, TBL[i].d);
         else begin
            do_read(TBL[i].a, v);
            check($sformatf("R%0d table %0d", TBL[i].req, i), v, TBL[i].e);
         end
      end

      // R5 mirror both directions
      do_read(4'h0, v); check("R5 ext to csr", v, 16'h00A1);
      do_write(1'b0, 4'h0, 16'h0090);
      check("R6 no start", {15'b0, cmd_start}, 16'h0000);
      do_read(4'h8, v); check("R5 csr to ext", v, 16'h0001);

      // R6 done=1 writes steer irq
      do_write(1'b0, 4'h0, 16'h00C0);
      check("R6 irq raised", {15'b0, irq}, 16'h0001);
      check("R6 no start ie", {15'b0, cmd_start}, 16'h0000);
      do_write(1'b0, 4'h0, 16'h0080);
      check("R6 irq dropped", {15'b0, irq}, 16'h0000);

      // R3 ready follows selected drive, byte write into csr
      drv_busy = 4'b0100;
      do_write(1'b0, 4'h0, 16'h0280);
      do_read(4'h0, v); check("R3 busy drive", v, 16'h0280);
      drv_busy = 4'b0000;
      do_read(4'h0, v); check("R3 idle drive", v, 16'h0281);
      do_write(1'b1, 4'h1, 16'h0001);
      do_read(4'h0, v); check("R2 csr high byte", v, 16'h0181);

      // R7 command launch
      do_write(1'b0, 4'h0, 16'h014C);
      check("R7 start", {15'b0, cmd_start}, 16'h0001);
      check("R7 func", {13'b0, cmd_func}, 16'h0006);
      check("R7 drive", {14'b0, cmd_drive}, 16'h0001);
      @(negedge clk);
      check("R7 one cycle", {15'b0, cmd_start}, 16'h0000);
      do_read(4'h0, v); check("R7 csr after start", v, 16'h014D);

      // R4 R11 completion with errors
      complete(5'b00101);
      do_read(4'h0, v); check("R4 error summary", v, 16'h95CD);
      check("R11 irq follows ie", {15'b0, irq}, 16'h0001);
      do_write(1'b0, 4'h0, 16'h7CC0);
      do_read(4'h0, v); check("R4 errors not writable", v, 16'h94C1);
      do_write(1'b0, 4'h0, 16'h014C);
      check("R7 irq cleared", {15'b0, irq}, 16'h0000);
      do_read(4'h0, v); check("R7 errors cleared", v, 16'h014D);

      // R11 completion without enable
      complete(5'b00000);
      do_read(4'h0, v); check("R11 done set", v, 16'h01CD);
      do_write(1'b0, 4'h0, 16'h0004);
      complete(5'b00000);
      check("R11 no irq without ie", {15'b0, irq}, 16'h0000);
      do_read(4'h0, v); check("R11 done ie0", v, 16'h0085);

      // R11 write wins over simultaneous completion
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h000C;
      xfer_done = 1'b1; xfer_err = 5'b11111;
      @(negedge clk);
      bus_wr = 1'b0; xfer_done = 1'b0; xfer_err = '0;
      check("R11 collide start", {15'b0, cmd_start}, 16'h0001);
      do_read(4'h0, v); check("R11 write wins", v, 16'h000D);
      complete(5'b00000);
      do_read(4'h0, v); check("R11 later completion", v, 16'h008D);

      // R8 multipurpose queue
      @(negedge clk);
      mp_set = 3'b111; mp_set_data = {16'h0F0F, 16'h5555, 16'hAAAA};
      @(negedge clk);
      mp_set = '0;
      do_read(4'h6, v); check("R8 head", v, 16'hAAAA);
      do_read(4'h6, v); check("R8 second", v, 16'h5555);
      do_read(4'h6, v); check("R8 third", v, 16'h0F0F);
      do_read(4'h6, v); check("R8 tail kept", v, 16'h0F0F);
      do_write(1'b1, 4'h7, 16'h00EE);
      do_read(4'h6, v); check("R8 byte load", v, 16'hEE0F);
      do_read(4'h6, v); check("R8 byte load e1", v, 16'hEE0F);
      do_write(1'b0, 4'h6, 16'h1234);
      do_read(4'h6, v); check("R8 word load", v, 16'h1234);
      do_read(4'h6, v); check("R8 word load e1", v, 16'h1234);
      do_read(4'h6, v); check("R8 word load e2", v, 16'h1234);

      // R10 legacy variant
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 4'h8;
      #1;
      check("R10 legacy bus_err", {15'b0, berr_l}, 16'h0001);
      check("R10 legacy rdata", rdata_l, 16'h0000);
      check("R10 full no bus_err", {15'b0, berr}, 16'h0000);
      @(negedge clk);
      bus_rd = 1'b0;
      do_write(1'b0, 4'h8, 16'h003F);
      do_read(4'h0, v); check("R5 full mirror", v, 16'h00BD);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 4'h0;
      #1 check("R10 legacy csr unchanged", rdata_l, 16'h008D);
      @(negedge clk);
      bus_rd = 1'b0;

      // R12 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_read(4'h0, v); check("R12 csr again", v, 16'h0081);
      do_read(4'h2, v); check("R12 bus address", v, 16'h0000);
      do_read(4'h4, v); check("R12 disk address", v, 16'h0000);
      do_read(4'h8, v); check("R12 ext", v, 16'h0000);
      do_read(4'h6, v); check("R12 mp again", v, 16'h0000);

      finish_run();
   end
endmodule